// File: doc/BRIEF.md
# Pulse-to-Square Clock Shaper

This block turns a narrow periodic pulse, typically an 8 kHz timing reference, into a square wave of roughly half duty cycle at the same rate. It runs on a fast sampling clock and watches an input that has already been brought into that clock domain. It counts the fast-clock cycles between successive rising edges of the input and keeps the most recent count as the measured period.

Every input rising edge drives one output edge with a fixed latency of one register, so that edge adds no jitter. The opposite output edge is generated half a measured period later, so it can be off by up to one fast-clock cycle from true 50%. A build-time polarity parameter selects the output polarity. With polarity zero, the tracked edge is a rising edge. With polarity one, it is a falling edge, which gives the inverted path. When the enable input is low, the input is passed straight to the output.

A period-valid flag shows whether a usable measurement is held. The fast clock is expected to run between 10 and 16000 times faster than the input.

Top module: `pulse_squarer`

## Requirements
- R1: After reset the internal wave level is low and period_valid is 0. With enable high, sq_out therefore shows the parameter INVERT (0 for the direct build, 1 for the inverted build).
- R2: With enable low, sq_out equals pulse_in in the same cycle in both builds, with no register on that path. Period measurement keeps running.
- R3: A rising edge of pulse_in, first seen high at clock edge k, moves the wave level to high at edge k. That wave level maps to sq_out=1 when INVERT=0 and sq_out=0 when INVERT=1. The latency is always exactly one edge.
- R4: The measured period is the number of clock edges between two successive rising edges. period_valid goes to 1 at the second rising edge after reset or after saturation, and stays 1 while edges keep arriving.
- R5: With a valid period P and a rising edge at clock edge k, the wave level goes low at edge k+floor(P/2). It holds low until the next rising edge, so the tracked level lasts floor(P/2) cycles of each period.
- R6: While period_valid is 0, no midpoint edge is made. Each rising edge sets the tracked level and the output then holds that level.
- R7: The polarity parameter INVERT inverts both output edges in enabled mode. It has no effect in bypass.
- R8: The period counter is 14 bits wide. After a rising edge at clock edge k with no further rising edge, period_valid is still 1 after edge k+16383 and is 0 after edge k+16384. The output holds its level. The next rising edge sets the tracked level without capturing a period.
- R9: When a rising edge and a midpoint edge fall on the same clock edge, the rising edge wins. The wave level stays high, and the new, shorter period takes effect.
- R10: Periods from 10 to 16000 clock cycles, odd or even, give exactly floor(P/2) cycles of tracked level per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Pulse input, already synchronized to clk |
| enable | input | 1 | 1: square-wave shaping, 0: pass pulse_in straight through |
| sq_out | output | 1 | Shaped square wave, or the bypassed input |
| period_valid | output | 1 | A usable period measurement is held |

## Verification
The tracked edge from a new input rising edge and the synthesized midpoint edge can land on the same clock edge when the input period suddenly halves. The bench first sets up a period of 40 and then sends the next pulse exactly 20 cycles after the previous one. That places the new rising edge on the very cycle the midpoint of the old period would fire. The outcome is judged at the ports. The output must stay at the tracked level for all 20 cycles of the short interval. The following interval must then split 10/10 using the newly measured period.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned CNT_W = 14;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX = '1;

  // half of a measured period, rounded down
  function automatic cnt_t half_of(cnt_t per);
    return per >> 1;
  endfunction

  // the cycle count reaches the midpoint on the coming edge
  function automatic logic mid_hit(cnt_t cnt, cnt_t per);
    return cnt_t'(cnt + 1'b1) == half_of(per);
  endfunction

  function automatic logic is_sat(cnt_t cnt);
    return cnt == CNT_MAX;
  endfunction
endpackage

// File: rtl/psq_edge_detect.sv
module psq_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/psq_period_meter.sv
module psq_period_meter
  import psq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output cnt_t cnt,
  output cnt_t period,
  output logic valid,
  output logic sat
);
  logic seen;

  assign sat = is_sat(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      period <= '0;
      valid  <= 1'b0;
      seen   <= 1'b0;
    end else if (rise) begin
      cnt  <= '0;
      seen <= 1'b1;
      if (seen && !sat) begin
        period <= cnt_t'(cnt + 1'b1);
        valid  <= 1'b1;
      end else begin
        valid  <= 1'b0;
      end
    end else if (sat) begin
      valid <= 1'b0;
    end else begin
      cnt <= cnt_t'(cnt + 1'b1);
    end
  end
endmodule

// File: rtl/psq_wave_gen.sv
module psq_wave_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic mid,
  output logic lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n)    lvl <= 1'b0;
    else if (rise) lvl <= 1'b1;   // tracked edge has priority
    else if (mid)  lvl <= 1'b0;
  end
endmodule

// File: rtl/pulse_squarer.sv
module pulse_squarer
  import psq_pkg::*;
#(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic enable,
  output logic sq_out,
  output logic period_valid
);
  // named internal events, watched by the bound checker
  logic rise_evt;
  logic mid_evt;
  logic wave_lvl;
  logic cnt_sat;
  logic shaped;
  cnt_t cnt;
  cnt_t period;

  psq_edge_detect u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pulse_in),
    .rise (rise_evt)
  );

  psq_period_meter u_meter (
    .clk   (clk),
    .rst_n (rst_n),
    .rise  (rise_evt),
    .cnt   (cnt),
    .period(period),
    .valid (period_valid),
    .sat   (cnt_sat)
  );

  assign mid_evt = period_valid & mid_hit(cnt, period);

  psq_wave_gen u_wave (
    .clk  (clk),
    .rst_n(rst_n),
    .rise (rise_evt),
    .mid  (mid_evt),
    .lvl  (wave_lvl)
  );

  generate
    if (INVERT) begin : g_inv
      assign shaped = ~wave_lvl;
    end else begin : g_dir
      assign shaped = wave_lvl;
    end
  endgenerate

  assign sq_out = enable ? shaped : pulse_in;
endmodule

// File: rtl/psq_checker.sv
module psq_checker (
  input logic clk,
  input logic rst_n,
  input logic rise_evt,
  input logic mid_evt,
  input logic wave_lvl,
  input logic period_valid,
  input logic cnt_sat
);
  assert_tracked_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> wave_lvl);

  assert_midpoint_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_evt && !rise_evt) |=> !wave_lvl);

  assert_only_two_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_evt && !mid_evt) |=> $stable(wave_lvl));

  assert_valid_from_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_valid) |-> $past(rise_evt));

  assert_sat_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sat && !rise_evt) |=> !period_valid);

  assert_rise_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && mid_evt) |=> wave_lvl);
endmodule

bind pulse_squarer psq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rise_evt    (rise_evt),
  .mid_evt     (mid_evt),
  .wave_lvl    (wave_lvl),
  .period_valid(period_valid),
  .cnt_sat     (cnt_sat)
);

// File: tb/pulse_squarer_tb.sv
module pulse_squarer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_in = 1'b0;
  logic enable = 1'b1;
  logic sq_out, sq_out_inv, pv, pv_inv;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_squarer #(.INVERT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .enable(enable),
    .sq_out(sq_out), .period_valid(pv));

  pulse_squarer #(.INVERT(1'b1)) u_dut_inv (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .enable(enable),
    .sq_out(sq_out_inv), .period_valid(pv_inv));

  // period, expected cycles of tracked level per period (floor(P/2))
  localparam int VEC [6][2] = '{'{10, 5}, '{11, 5}, '{37, 18},
                                '{100, 50}, '{1001, 500}, '{16000, 8000}};

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one input period of p cycles, starting right after a negedge
  task automatic run_period(input int p, output int hi, output int first,
                            output int lo_inv, output int first_inv);
    hi = 0; lo_inv = 0; first = 0; first_inv = 0;
    for (int i = 0; i < p; i++) begin
      pulse_in = (i == 0);
      @(negedge clk);
      if (i == 0) begin
        first = sq_out;
        first_inv = sq_out_inv;
      end
      hi += int'(sq_out);
      lo_inv += int'(!sq_out_inv);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hi, first, lo, first_inv;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sq_out direct", int'(sq_out), 0);
    check("R1 sq_out inverted", int'(sq_out_inv), 1);
    check("R1 period_valid", int'(pv), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 first edge only: tracked level held, no midpoint
    run_period(30, hi, first, lo, first_inv);
    check("R6 no midpoint before valid", hi, 30);
    check("R3 first tracked edge", first, 1);
    check("R6 valid still low", int'(pv), 0);

    // R10 / R5 / R7 vector walk
    for (int v = 0; v < 6; v++) begin
      for (int r = 0; r < 3; r++) begin
        run_period(VEC[v][0], hi, first, lo, first_inv);
        if (v == 0 && r == 0) check("R4 valid after second edge", int'(pv), 1);
      end
      check("R10 high cycles", hi, VEC[v][1]);
      check("R7 inverted tracked cycles", lo, VEC[v][1]);
      check("R3 tracked edge latency", first, 1);
      check("R7 inverted tracked edge", first_inv, 0);
      check("R4 valid held", int'(pv), 1);
    end

    // R9 coincidence of new edge and old midpoint
    run_period(40, hi, first, lo, first_inv);
    run_period(40, hi, first, lo, first_inv);
    check("R5 period 40 split", hi, 20);
    run_period(20, hi, first, lo, first_inv);
    check("R9 rise wins over midpoint", hi, 20);
    run_period(20, hi, first, lo, first_inv);
    check("R9 next period split", hi, 10);
    check("R9 tracked level at new edge", first, 1);

    // R8 saturation
    pulse_in = 1'b1;
    @(negedge clk);
    pulse_in = 1'b0;
    repeat (16383) @(negedge clk);
    check("R8 valid before saturation", int'(pv), 1);
    @(negedge clk);
    check("R8 valid cleared", int'(pv), 0);
    check("R8 output holds", int'(sq_out), 0);
    run_period(50, hi, first, lo, first_inv);
    check("R8 no capture after saturation", int'(pv), 0);
    check("R6 no midpoint after saturation", hi, 50);
    run_period(50, hi, first, lo, first_inv);
    check("R4 valid again", int'(pv), 1);
    check("R5 split after recovery", hi, 25);

    // R2 bypass
    enable = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pulse_in = k[0];
      #1;
      check("R2 bypass direct", int'(sq_out), k & 1);
      check("R2 bypass inverted build", int'(sq_out_inv), k & 1);
      @(negedge clk);
    end
    pulse_in = 1'b0;
    @(negedge clk);
    check("R2 measuring continues", int'(pv), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule